// File: doc/BRIEF.md
# Retriggerable Resettable Digital One-Shot

This block is a synchronous monostable pulse generator. Its pulse length is set by a loadable down-counter that counts clock cycles, so no resistor or capacitor sets the timing. Two trigger pins can start a pulse. One reacts to a rising edge and the other to a falling edge. Each is qualified by the level of the other pin, so one trigger can act as an enable for the other. Both trigger pins pass through two-flop synchronizers before edge detection. This gives a fixed trigger-to-output latency.

A mode pin selects how triggers that arrive during a pulse are handled. In retriggerable mode, such a trigger reloads the counter and the pulse is stretched. In lock-out mode, such a trigger is ignored. An active-low clear pin ends a pulse and blocks new ones while it is held. Clear and trigger have fixed priority when they change in the same cycle. The pulse output and its complement are registered.

The control is a three-state machine:
- `ST_IDLE`: no pulse.
- `ST_PULSE`: pulse running.
- `ST_CLEARED`: clear is held.

The named transitions are:
- *start*: IDLE→PULSE on an accepted trigger.
- *reload*: PULSE→PULSE on a trigger when lock-out is off.
- *tick*: PULSE→PULSE with a count-down.
- *expire*: PULSE→IDLE when the last cycle ends.
- *abort*: any state→CLEARED while clear is low.
- *resume*: CLEARED→IDLE on release.
- *resume-start*: CLEARED→PULSE on release together with a trigger.

Top module: `retrig_oneshot`

## Requirements
- R1: While and directly after synchronous reset `rst`, `q_o` is 0 and `q_n_o` is 1.
- R2: Out of reset, `q_n_o` is always the inverse of `q_o`.
- R3: A 0→1 change on `trig_rise_i`, while `trig_fall_i` is 1, starts a pulse. If the new level is first sampled at clock edge E, `q_o` rises at edge E+2.
- R4: A 1→0 change on `trig_fall_i`, while `trig_rise_i` is 0, starts a pulse with the same latency as R3.
- R5: A rising edge on `trig_rise_i` while `trig_fall_i` is 0 does not start a pulse. A falling edge on `trig_fall_i` while `trig_rise_i` is 1 does not start a pulse.
- R6: A pulse lasts N cycles. N is the value of `len_i` captured when the trigger is accepted, and `len_i` = 0 counts as N = 1. Changes to `len_i` after acceptance do not alter the running pulse.
- R7: With `lockout_i` = 0, a trigger during a pulse reloads the count, and `q_o` stays 1 without a gap.
- R8: With `lockout_i` = 1, a trigger during a pulse is ignored, and the pulse ends on its original schedule.
- R9: `clr_n` = 0 at an edge forces `q_o` to 0 after that edge. While `clr_n` stays 0, no pulse starts.
- R10: If `clr_n` is 0 in the cycle an accepted trigger takes effect, clear wins and no pulse starts. If `clr_n` returns to 1 in that cycle, the pulse starts.
- R11: Trigger levels present during reset never start a pulse. Edge detection is disabled for the first SYNC_STAGES+1 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Clear, active low, synchronous to clk |
| trig_rise_i | input | 1 | Trigger on rising edge, asynchronous |
| trig_fall_i | input | 1 | Trigger on falling edge, asynchronous |
| lockout_i | input | 1 | 1 = ignore triggers during a pulse |
| len_i | input | LEN_W | Pulse length in cycles (0 acts as 1) |
| q_o | output | 1 | Pulse output |
| q_n_o | output | 1 | Complement of q_o |

## Verification
The bound checker watches several properties on every cycle:
- the two outputs stay complementary;
- clear forces the output low;
- an accepted trigger starts a pulse and loads the captured length;
- the last count ends the pulse;
- a reload keeps the output high;
- lock-out lets the count continue down untouched.

Other behaviour can only be shown by the bench scenarios, because it depends on the raw pins and on absolute timing. This covers the trigger gating between the two pins, the synchronizer latency, the warm-up after reset, and whether clear and trigger coincide at the right cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PULSE   = 2'd1,
        ST_CLEARED = 2'd2
    } os_state_e;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/oneshot_trig_detect.sv
module oneshot_trig_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_raw,
    input  logic fall_raw,
    output logic fire
);
    localparam int WARM = STAGES + 1;
    localparam int WW   = $clog2(WARM + 1);

    logic [1:0]    raw;
    logic [1:0]    lvl;
    logic [1:0]    prev;
    logic [WW-1:0] warm;
    logic          armed;
    logic          rise_ok;
    logic          fall_ok;

    // index 0: rising-edge trigger pin, index 1: falling-edge trigger pin
    assign raw = {fall_raw, rise_raw};

    for (genvar i = 0; i < 2; i++) begin : g_sync
        oneshot_sync #(.STAGES(STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[i]),
            .q   (lvl[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    // edges are only trusted once the synchronizers hold post-reset data
    always_ff @(posedge clk) begin
        if (rst)                     warm <= '0;
        else if (warm != WW'(WARM))  warm <= warm + 1'b1;
    end

    assign armed   = (warm == WW'(WARM));
    assign rise_ok = lvl[0] & ~prev[0] & lvl[1];
    assign fall_ok = ~lvl[1] & prev[1] & ~lvl[0];
    assign fire    = armed & (rise_ok | fall_ok);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] cnt,
    output logic             last
);
    logic [LEN_W-1:0] ld_val;

    assign ld_val = (len == '0) ? LEN_W'(1) : len;

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == LEN_W'(1));
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             trig_rise_i,
    input  logic             trig_fall_i,
    input  logic             lockout_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             q_o,
    output logic             q_n_o
);
    os_state_e        state;
    os_state_e        state_nx;
    logic             trig_fire;
    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_last;
    logic [LEN_W-1:0] cnt_cur;

    oneshot_trig_detect #(.STAGES(SYNC_STAGES)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .rise_raw (trig_rise_i),
        .fall_raw (trig_fall_i),
        .fire     (trig_fire)
    );

    oneshot_timer #(.LEN_W(LEN_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .dec  (tmr_dec),
        .len  (len_i),
        .cnt  (cnt_cur),
        .last (tmr_last)
    );

    // next-state and timer commands; clear dominates every transition
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        if (!clr_n) begin
            state_nx = ST_CLEARED;                     // abort
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trig_fire) begin               // start
                        state_nx = ST_PULSE;
                        tmr_load = 1'b1;
                    end
                end
                ST_CLEARED: begin
                    if (trig_fire) begin               // resume-start
                        state_nx = ST_PULSE;
                        tmr_load = 1'b1;
                    end else begin                     // resume
                        state_nx = ST_IDLE;
                    end
                end
                ST_PULSE: begin
                    if (trig_fire && !lockout_i) begin // reload
                        tmr_load = 1'b1;
                    end else if (tmr_last) begin       // expire
                        state_nx = ST_IDLE;
                    end else begin                     // tick
                        tmr_dec = 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // output register pair
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o   <= 1'b0;
            q_n_o <= 1'b1;
        end else begin
            q_o   <= (state_nx == ST_PULSE);
            q_n_o <= (state_nx != ST_PULSE);
        end
    end
endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n,
    input logic             lockout_i,
    input logic [LEN_W-1:0] len_i,
    input logic             fire,
    input logic [LEN_W-1:0] cnt,
    input logic             q_o,
    input logic             q_n_o
);
    // R2
    complement_chk: assert property (@(posedge clk) disable iff (rst)
        q_o != q_n_o);

    // R9
    clear_ends_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> !q_o);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_o && fire && clr_n) |=> q_o);

    // R6
    len_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_o && fire && clr_n) |=>
        (cnt == (($past(len_i) == '0) ? LEN_W'(1) : $past(len_i))));

    // R6
    expire_chk: assert property (@(posedge clk) disable iff (rst)
        (q_o && cnt == LEN_W'(1) && !(fire && !lockout_i) && clr_n) |=> !q_o);

    // R7
    retrig_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q_o && fire && !lockout_i && clr_n) |=> q_o);

    // R8
    lockout_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (q_o && fire && lockout_i && clr_n && cnt != LEN_W'(1)) |=>
        (q_o && cnt == $past(cnt) - LEN_W'(1)));
endmodule

bind retrig_oneshot retrig_oneshot_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .lockout_i (lockout_i),
    .len_i     (len_i),
    .fire      (trig_fire),
    .cnt       (cnt_cur),
    .q_o       (q_o),
    .q_n_o     (q_n_o)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr_n = 1'b1;
    logic             trig_rise_i = 1'b1;
    logic             trig_fall_i = 1'b1;
    logic             lockout_i = 1'b0;
    logic [LEN_W-1:0] len_i = 16'd4;
    logic             q_o;
    logic             q_n_o;

    int    tests = 0;
    int    fails = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit hr[3];
    bit hf[3];
    int since_rst = 0;
    bit m_q = 1'b0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    retrig_oneshot #(.LEN_W(LEN_W), .SYNC_STAGES(2)) dut (
        .clk         (clk),
        .rst         (rst),
        .clr_n       (clr_n),
        .trig_rise_i (trig_rise_i),
        .trig_fall_i (trig_fall_i),
        .lockout_i   (lockout_i),
        .len_i       (len_i),
        .q_o         (q_o),
        .q_n_o       (q_n_o)
    );

    // reference model: accepted edge = pin value two samples back vs three back
    always @(posedge clk) begin
        if (rst) begin
            m_q = 1'b0;
            m_cnt = 0;
            since_rst = 0;
            for (int i = 0; i < 3; i++) begin
                hr[i] = 1'b0;
                hf[i] = 1'b0;
            end
        end else begin
            bit go;
            go = (since_rst >= 3) &&
                 ((hr[1] && !hr[2] && hf[1]) || (!hf[1] && hf[2] && !hr[1]));
            if (!clr_n) begin
                m_q = 1'b0;
            end else if (go && (!m_q || !lockout_i)) begin
                m_q = 1'b1;
                m_cnt = (len_i == 0) ? 1 : int'(len_i);
            end else if (m_q) begin
                if (m_cnt == 1) m_q = 1'b0;
                else            m_cnt = m_cnt - 1;
            end
            hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = trig_rise_i;
            hf[2] = hf[1]; hf[1] = hf[0]; hf[0] = trig_fall_i;
            if (since_rst < 3) since_rst++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            tests++;
            if (q_o !== m_q) begin
                fails++;
                $display("FAIL %s: q_o=%b expected %b", cur_req, q_o, m_q);
            end
            tests++;
            if (q_n_o !== !m_q) begin
                fails++;
                $display("FAIL R2: q_n_o=%b expected %b", q_n_o, !m_q);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: reset with both trigger pins high (also sets up R11)
        step(3);
        chk(q_o, 1'b0, "R1");
        chk(q_n_o, 1'b1, "R1");
        cmp_en = 1'b1;
        rst = 1'b0;
        cur_req = "R11";
        step(8);
        chk(q_o, 1'b0, "R11");
        trig_rise_i = 1'b0;
        step(4);

        // R3: rising trigger, latency and 4-cycle width
        cur_req = "R3";
        trig_rise_i = 1'b1;
        step(1); chk(q_o, 1'b0, "R3");
        step(1); chk(q_o, 1'b0, "R3");
        step(1); chk(q_o, 1'b1, "R3");
        step(3); chk(q_o, 1'b1, "R6");
        step(1); chk(q_o, 1'b0, "R6");
        trig_rise_i = 1'b0;
        step(4);

        // R6: zero length acts as one
        cur_req = "R6";
        len_i = '0;
        trig_rise_i = 1'b1;
        step(3); chk(q_o, 1'b1, "R6");
        step(1); chk(q_o, 1'b0, "R6");
        trig_rise_i = 1'b0;
        step(4);
        // R6: length captured at acceptance
        len_i = 16'd9;
        trig_rise_i = 1'b1;
        step(3);
        len_i = 16'd2;
        chk(q_o, 1'b1, "R6");
        step(8); chk(q_o, 1'b1, "R6");
        step(1); chk(q_o, 1'b0, "R6");
        trig_rise_i = 1'b0;
        len_i = 16'd4;
        step(4);

        // R4: falling trigger with rise pin low
        cur_req = "R4";
        trig_fall_i = 1'b0;
        step(3); chk(q_o, 1'b1, "R4");
        step(4); chk(q_o, 1'b0, "R4");
        trig_fall_i = 1'b1;
        step(4);

        // R5: gated edges
        cur_req = "R5";
        trig_rise_i = 1'b1;
        step(10);
        trig_fall_i = 1'b0;
        step(6); chk(q_o, 1'b0, "R5");
        trig_rise_i = 1'b0;
        step(4);
        trig_rise_i = 1'b1;
        step(6); chk(q_o, 1'b0, "R5");
        trig_rise_i = 1'b0;
        step(4);
        trig_fall_i = 1'b1;
        step(4);

        // R7: retrigger stretches the pulse
        cur_req = "R7";
        lockout_i = 1'b0;
        len_i = 16'd6;
        trig_rise_i = 1'b1;
        step(3);
        for (int k = 0; k < 3; k++) begin
            trig_rise_i = 1'b0;
            step(2); chk(q_o, 1'b1, "R7");
            trig_rise_i = 1'b1;
            step(2); chk(q_o, 1'b1, "R7");
        end
        trig_rise_i = 1'b0;
        step(12); chk(q_o, 1'b0, "R7");

        // R8: lock-out ignores retrigger
        cur_req = "R8";
        lockout_i = 1'b1;
        trig_rise_i = 1'b1;
        step(3);
        trig_rise_i = 1'b0;
        step(2);
        trig_rise_i = 1'b1;
        step(1);
        trig_rise_i = 1'b0;
        step(3); chk(q_o, 1'b0, "R8");
        step(4);
        lockout_i = 1'b0;

        // R9: clear ends pulse and blocks triggers
        cur_req = "R9";
        len_i = 16'd20;
        trig_rise_i = 1'b1;
        step(3); chk(q_o, 1'b1, "R9");
        step(2);
        clr_n = 1'b0;
        step(1); chk(q_o, 1'b0, "R9");
        trig_rise_i = 1'b0;
        step(2);
        trig_rise_i = 1'b1;
        step(4); chk(q_o, 1'b0, "R9");
        trig_rise_i = 1'b0;
        step(3);
        clr_n = 1'b1;
        step(4); chk(q_o, 1'b0, "R9");

        // R10: clear asserting with the trigger wins
        cur_req = "R10";
        len_i = 16'd4;
        trig_rise_i = 1'b1;
        step(2);
        clr_n = 1'b0;
        step(1); chk(q_o, 1'b0, "R10");
        step(2);
        clr_n = 1'b1;
        trig_rise_i = 1'b0;
        step(4); chk(q_o, 1'b0, "R10");
        // R10: clear releasing with the trigger lets it through
        clr_n = 1'b0;
        step(2);
        trig_rise_i = 1'b1;
        step(2);
        clr_n = 1'b1;
        step(1); chk(q_o, 1'b1, "R10");
        trig_rise_i = 1'b0;
        step(10);

        finish_run();
    end
endmodule